// File: doc/BRIEF.md
# Shadow RAM Segment Access Decoder

This block sits on the upper-memory path of a chipset. It decides, for every access in the 0xC0000–0xFFFFF window, whether the access goes to on-board DRAM or out to the external bus. Reads and writes are routed on their own terms, so a ROM region can be read from the bus and written into DRAM during shadowing, and then read from DRAM once it has been copied.

The window is split into twelve 16 KiB segments from 0xC0000 to 0xEFFFF, plus one 64 KiB segment from 0xF0000 to 0xFFFFF. Four byte-wide configuration registers hold the enables. They are written and read back through a simple offset/data port. Routing follows the register contents combinationally, so a register write changes the routing from the access that follows the clock edge on which the write lands.

Top module: `shadow_seg_decoder`

## Requirements
- R1: Addresses 0xC0000–0xEFFFF form twelve 16 KiB segments, with segment index i = (address − 0xC0000) >> 14. 0xC3FFF falls in segment 0 and 0xC4000 falls in segment 1.
- R2: Segment i is controlled by the register at offset 0x44 + ((i >> 2) XOR 3). Offset 0x47 governs 0xC0000–0xCFFFF, 0x46 governs 0xD0000–0xDFFFF and 0x45 governs 0xE0000–0xEFFFF.
- R3: In the controlling register, bit (i & 3) is the internal-write enable of segment i and bit (i & 3) + 4 is its internal-read enable.
- R4: 0xF0000–0xFFFFF is governed by offset 0x44. Bit 0 enables internal writes and bit 1 enables internal reads.
- R5: A write to offset 0x44 keeps only the bits under mask 0xCB. The other bits read back as zero, so writing 0xFF reads back 0xCB.
- R6: A write to offset 0x45, 0x46 or 0x47 stores the whole byte, and it reads back unchanged from the next cycle on.
- R7: A valid access inside the window asserts sel_int_o when its enable bit (write enable for writes, read enable for reads) is 1, and asserts sel_ext_o when that bit is 0.
- R8: A register write takes effect at the clock edge that captures it. An access in the same cycle as the write is routed with the old value, and the next access is routed with the new one.
- R9: Reset clears all four registers to zero, so every access in the window is routed to the external bus.
- R10: A valid access below 0xC0000 always asserts sel_int_o, whatever the register contents.
- R11: A valid access asserts exactly one of sel_int_o and sel_ext_o. When mem_valid_i is low, both are low.
- R12: Offsets other than 0x44–0x47 read as zero, and writes to them change no register and no routing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_addr_i | input | 8 | Configuration register offset |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_rdata_o | output | 8 | Read data for cfg_addr_i |
| mem_addr_i | input | 20 | Memory access address |
| mem_valid_i | input | 1 | Memory access qualifier |
| mem_write_i | input | 1 | 1 = write access, 0 = read access |
| sel_int_o | output | 1 | Route the access to internal DRAM |
| sel_ext_o | output | 1 | Route the access to the external bus |

## Verification
The case that matters is a configuration write and a memory access landing in the same cycle. The access must still follow the old enable bits, and the following access must follow the new ones. The bench provokes this in a directed step: it rewrites offset 0x47 while writing to 0xC0000 in the same cycle, then repeats the access on the next cycle. Random cycles also mix writes and accesses to the same register freely. Every cycle, the reference model routes the access with the register state from before the edge and only then applies the write, so each overlap is judged against the old value.

// File: rtl/shd_pkg.sv
package shd_pkg;
  localparam int unsigned ADDR_W = 20;
  localparam int unsigned CFG_W  = 8;
  localparam int unsigned EN_PER_REG = CFG_W / 2;  // one nibble of write enables, one of read enables

  typedef struct packed {
    logic              valid;
    logic              write;
    logic [ADDR_W-1:0] addr;
  } mem_req_t;
endpackage

// File: rtl/shd_cfg_regs.sv
module shd_cfg_regs
  import shd_pkg::*;
#(
  parameter int unsigned     NUM_REGS  = 4,
  parameter logic [CFG_W-1:0] BASE_OFF  = 8'h44,
  parameter logic [CFG_W-1:0] REG0_MASK = 8'hCB
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic [CFG_W-1:0]                   cfg_addr_i,
  input  logic [CFG_W-1:0]                   cfg_wdata_i,
  input  logic                               cfg_we_i,
  output logic [CFG_W-1:0]                   cfg_rdata_o,
  output logic [NUM_REGS-2:0][CFG_W-1:0]     win_regs_o,
  output logic [1:0]                         top_pair_o
);
  logic [CFG_W-1:0] regs_q [NUM_REGS];

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    localparam logic [CFG_W-1:0] OFF  = BASE_OFF + CFG_W'(k);
    localparam logic [CFG_W-1:0] MASK = (k == 0) ? REG0_MASK : {CFG_W{1'b1}};
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          regs_q[k] <= '0;
      else if (cfg_we_i && cfg_addr_i == OFF) regs_q[k] <= cfg_wdata_i & MASK;
    end
    if (k > 0) begin : g_win
      assign win_regs_o[k-1] = regs_q[k];
    end
  end

  assign top_pair_o = regs_q[0][1:0];

  always_comb begin
    cfg_rdata_o = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (cfg_addr_i == BASE_OFF + CFG_W'(k)) cfg_rdata_o = regs_q[k];
    end
  end
endmodule

// File: rtl/shd_seg_enables.sv
module shd_seg_enables
  import shd_pkg::*;
#(
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned NUM_SEGS = 12,
  parameter int unsigned SEG_W    = 4,
  localparam int unsigned NSEG_P2 = 1 << SEG_W
) (
  input  logic [NUM_REGS-2:0][CFG_W-1:0] win_regs_i,
  output logic [NSEG_P2-1:0]             wr_en_o,
  output logic [NSEG_P2-1:0]             rd_en_o
);
  // lowest segments sit in the highest register
  for (genvar i = 0; i < NSEG_P2; i++) begin : g_seg
    if (i < NUM_SEGS) begin : g_used
      localparam int unsigned RI = NUM_REGS - 2 - (i / EN_PER_REG);
      localparam int unsigned BI = i % EN_PER_REG;
      assign wr_en_o[i] = win_regs_i[RI][BI];
      assign rd_en_o[i] = win_regs_i[RI][BI + EN_PER_REG];
    end else begin : g_pad
      assign wr_en_o[i] = 1'b0;
      assign rd_en_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/shd_route.sv
module shd_route
  import shd_pkg::*;
#(
  parameter logic [ADDR_W-1:0] WIN_BASE  = 20'hC0000,
  parameter logic [ADDR_W-1:0] TOP_BASE  = 20'hF0000,
  parameter int unsigned       SEG_SHIFT = 14,
  parameter int unsigned       SEG_W     = 4,
  localparam int unsigned      NSEG_P2   = 1 << SEG_W
) (
  input  mem_req_t           req_i,
  input  logic [NSEG_P2-1:0] wr_en_i,
  input  logic [NSEG_P2-1:0] rd_en_i,
  input  logic [1:0]         top_pair_i,
  output logic               sel_int_o,
  output logic               sel_ext_o
);
  logic [SEG_W-1:0] seg;
  logic             hit;

  assign seg = SEG_W'((req_i.addr - WIN_BASE) >> SEG_SHIFT);

  always_comb begin
    if (req_i.addr < WIN_BASE)       hit = 1'b1;
    else if (req_i.addr >= TOP_BASE) hit = req_i.write ? top_pair_i[0] : top_pair_i[1];
    else                             hit = req_i.write ? wr_en_i[seg] : rd_en_i[seg];
  end

  assign sel_int_o = req_i.valid & hit;
  assign sel_ext_o = req_i.valid & ~hit;
endmodule

// File: rtl/shadow_seg_decoder.sv
module shadow_seg_decoder
  import shd_pkg::*;
#(
  parameter logic [ADDR_W-1:0] WIN_BASE  = 20'hC0000,
  parameter logic [ADDR_W-1:0] TOP_BASE  = 20'hF0000,
  parameter int unsigned       SEG_SHIFT = 14,
  parameter int unsigned       NUM_REGS  = 4,
  parameter logic [CFG_W-1:0]  BASE_OFF  = 8'h44,
  parameter logic [CFG_W-1:0]  REG0_MASK = 8'hCB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CFG_W-1:0]  cfg_addr_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  input  logic              cfg_we_i,
  output logic [CFG_W-1:0]  cfg_rdata_o,
  input  logic [ADDR_W-1:0] mem_addr_i,
  input  logic              mem_valid_i,
  input  logic              mem_write_i,
  output logic              sel_int_o,
  output logic              sel_ext_o
);
  localparam int unsigned NUM_SEGS = int'((TOP_BASE - WIN_BASE) >> SEG_SHIFT);
  localparam int unsigned SEG_W    = $clog2(NUM_SEGS);
  localparam int unsigned NSEG_P2  = 1 << SEG_W;

  logic [NUM_REGS-2:0][CFG_W-1:0] win_regs;
  logic [1:0]                     top_pair;
  logic [NSEG_P2-1:0]             wr_en, rd_en;
  mem_req_t                       req;

  assign req = '{valid: mem_valid_i, write: mem_write_i, addr: mem_addr_i};

  shd_cfg_regs #(
    .NUM_REGS (NUM_REGS),
    .BASE_OFF (BASE_OFF),
    .REG0_MASK(REG0_MASK)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_addr_i (cfg_addr_i),
    .cfg_wdata_i(cfg_wdata_i),
    .cfg_we_i   (cfg_we_i),
    .cfg_rdata_o(cfg_rdata_o),
    .win_regs_o (win_regs),
    .top_pair_o (top_pair)
  );

  shd_seg_enables #(
    .NUM_REGS(NUM_REGS),
    .NUM_SEGS(NUM_SEGS),
    .SEG_W   (SEG_W)
  ) u_en (
    .win_regs_i(win_regs),
    .wr_en_o   (wr_en),
    .rd_en_o   (rd_en)
  );

  shd_route #(
    .WIN_BASE (WIN_BASE),
    .TOP_BASE (TOP_BASE),
    .SEG_SHIFT(SEG_SHIFT),
    .SEG_W    (SEG_W)
  ) u_route (
    .req_i     (req),
    .wr_en_i   (wr_en),
    .rd_en_i   (rd_en),
    .top_pair_i(top_pair),
    .sel_int_o (sel_int_o),
    .sel_ext_o (sel_ext_o)
  );
endmodule

// File: rtl/shd_decoder_chk.sv
module shd_decoder_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [7:0]  cfg_addr_i,
  input logic [7:0]  cfg_wdata_i,
  input logic        cfg_we_i,
  input logic [7:0]  cfg_rdata_o,
  input logic [19:0] mem_addr_i,
  input logic        mem_valid_i,
  input logic        mem_write_i,
  input logic        sel_int_o,
  input logic        sel_ext_o
);
  p_one_sel_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_i |-> $countones({sel_int_o, sel_ext_o}) == 1);

  p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_valid_i |-> !sel_int_o && !sel_ext_o);

  p_low_internal_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_i && mem_addr_i < 20'hC0000) |-> sel_int_o);

  p_top_reg_masked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_addr_i == 8'h44) |-> (cfg_rdata_o & 8'h34) == 8'h00);

  p_oob_zero_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_addr_i < 8'h44 || cfg_addr_i > 8'h47) |-> cfg_rdata_o == 8'h00);

  p_full_store_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(cfg_we_i) && $past(cfg_addr_i) >= 8'h45 &&
     $past(cfg_addr_i) <= 8'h47 && $stable(cfg_addr_i))
    |-> cfg_rdata_o == $past(cfg_wdata_i));

  p_reset_clear_r9: assert property (@(posedge clk_i)
    !rst_ni |-> cfg_rdata_o == 8'h00);
endmodule

bind shadow_seg_decoder shd_decoder_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_addr_i (cfg_addr_i),
  .cfg_wdata_i(cfg_wdata_i),
  .cfg_we_i   (cfg_we_i),
  .cfg_rdata_o(cfg_rdata_o),
  .mem_addr_i (mem_addr_i),
  .mem_valid_i(mem_valid_i),
  .mem_write_i(mem_write_i),
  .sel_int_o  (sel_int_o),
  .sel_ext_o  (sel_ext_o)
);

// File: tb/shadow_seg_decoder_test.sv
module shadow_seg_decoder_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  cfg_addr = '0, cfg_wdata = '0, cfg_rdata;
  logic        cfg_we = 1'b0;
  logic [19:0] mem_addr = '0;
  logic        mem_valid = 1'b0, mem_write = 1'b0;
  logic        sel_int, sel_ext;

  int checks = 0;
  int errors = 0;

  logic [7:0] m_regs [4];
  logic       s_int, s_ext;
  logic [7:0] s_rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  shadow_seg_decoder uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata), .cfg_we_i(cfg_we),
    .cfg_rdata_o(cfg_rdata),
    .mem_addr_i(mem_addr), .mem_valid_i(mem_valid), .mem_write_i(mem_write),
    .sel_int_o(sel_int), .sel_ext_o(sel_ext)
  );

  function automatic logic exp_int(input logic [19:0] a, input logic wr);
    int seg, ri, bi;
    if (a < 20'hC0000) return 1'b1;
    if (a >= 20'hF0000) return wr ? m_regs[0][0] : m_regs[0][1];
    seg = int'((a - 20'hC0000) / 20'h4000);
    ri  = 3 - (seg / 4);
    bi  = (seg % 4) + (wr ? 0 : 4);
    return m_regs[ri][bi];
  endfunction

  function automatic logic [7:0] exp_rd(input logic [7:0] off);
    if (off >= 8'h44 && off <= 8'h47) return m_regs[off - 8'h44];
    return 8'h00;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // drive one cycle, sample before the edge, then apply the write to the model
  task automatic step(input string tag, input logic [7:0] ca, input logic [7:0] cd,
                      input logic cwe, input logic [19:0] ma, input logic mv, input logic mw);
    string rtag;
    @(negedge clk);
    cfg_addr = ca; cfg_wdata = cd; cfg_we = cwe;
    mem_addr = ma; mem_valid = mv; mem_write = mw;
    #1;
    s_int = sel_int; s_ext = sel_ext; s_rd = cfg_rdata;
    if (mv) begin
      chk((ma < 20'hC0000) ? "R10" : tag, {31'd0, s_int}, {31'd0, exp_int(ma, mw)});
      chk("R11", {31'd0, s_ext}, {31'd0, ~exp_int(ma, mw)});
    end else begin
      chk("R11", {30'd0, s_int, s_ext}, 32'd0);
    end
    rtag = (ca == 8'h44) ? "R5" : (ca >= 8'h45 && ca <= 8'h47) ? "R6" : "R12";
    chk(rtag, {24'd0, s_rd}, {24'd0, exp_rd(ca)});
    @(posedge clk);
    if (cwe) begin
      if (ca == 8'h44) m_regs[0] = cd & 8'hCB;
      else if (ca >= 8'h45 && ca <= 8'h47) m_regs[ca - 8'h44] = cd;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4; k++) m_regs[k] = 8'h00;
    void'($urandom(32'd7331));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;

    // R9: reset state
    for (int k = 0; k < 4; k++) begin
      step("R9", 8'(8'h44 + k), 8'h00, 1'b0, 20'hC0000, 1'b1, 1'b1);
      chk("R9", {24'd0, s_rd}, 32'h0);
      chk("R9", {31'd0, s_ext}, 32'd1);
    end
    step("R9", 8'h44, 8'h00, 1'b0, 20'hF0000, 1'b1, 1'b0);
    chk("R9", {31'd0, s_ext}, 32'd1);

    // R10: below window, all enables clear
    step("R10", 8'h00, 8'h00, 1'b0, 20'hBFFFF, 1'b1, 1'b1);
    chk("R10", {31'd0, s_int}, 32'd1);
    step("R10", 8'h00, 8'h00, 1'b0, 20'h00000, 1'b1, 1'b0);
    chk("R10", {31'd0, s_int}, 32'd1);

    // R5 mask, R4 top segment
    step("R5", 8'h44, 8'hFF, 1'b1, 20'hF0000, 1'b0, 1'b0);
    step("R5", 8'h44, 8'h00, 1'b0, 20'hF0000, 1'b1, 1'b1);
    chk("R5", {24'd0, s_rd}, 32'hCB);
    chk("R4", {31'd0, s_int}, 32'd1);
    step("R4", 8'h44, 8'h00, 1'b0, 20'hFFFFF, 1'b1, 1'b0);
    chk("R4", {31'd0, s_int}, 32'd1);
    step("R4", 8'h44, 8'h02, 1'b1, 20'h00000, 1'b0, 1'b0);
    step("R4", 8'h44, 8'h00, 1'b0, 20'hF8000, 1'b1, 1'b1);
    chk("R4", {31'd0, s_ext}, 32'd1);

    // R3 / R1: 0x47 = read enable of segment 0 only
    step("R3", 8'h47, 8'h10, 1'b1, 20'h00000, 1'b0, 1'b0);
    step("R3", 8'h47, 8'h00, 1'b0, 20'hC0000, 1'b1, 1'b0);
    chk("R3", {31'd0, s_int}, 32'd1);
    step("R3", 8'h47, 8'h00, 1'b0, 20'hC0000, 1'b1, 1'b1);
    chk("R3", {31'd0, s_ext}, 32'd1);
    step("R1", 8'h47, 8'h00, 1'b0, 20'hC3FFF, 1'b1, 1'b0);
    chk("R1", {31'd0, s_int}, 32'd1);
    step("R1", 8'h47, 8'h00, 1'b0, 20'hC4000, 1'b1, 1'b0);
    chk("R1", {31'd0, s_ext}, 32'd1);

    // R2: 0x46 and 0x45 govern the D and E blocks
    step("R6", 8'h46, 8'hA5, 1'b1, 20'h00000, 1'b0, 1'b0);
    step("R6", 8'h46, 8'h00, 1'b0, 20'hD0000, 1'b1, 1'b1);
    chk("R6", {24'd0, s_rd}, 32'hA5);
    chk("R2", {31'd0, s_int}, 32'd1);
    step("R2", 8'h46, 8'h00, 1'b0, 20'hD0000, 1'b1, 1'b0);
    chk("R2", {31'd0, s_ext}, 32'd1);
    step("R2", 8'h46, 8'h00, 1'b0, 20'hD4000, 1'b1, 1'b0);
    chk("R2", {31'd0, s_int}, 32'd1);
    step("R2", 8'h46, 8'h00, 1'b0, 20'hDC000, 1'b1, 1'b1);
    chk("R2", {31'd0, s_ext}, 32'd1);
    step("R2", 8'h45, 8'h88, 1'b1, 20'h00000, 1'b0, 1'b0);
    step("R2", 8'h45, 8'h00, 1'b0, 20'hEFFFF, 1'b1, 1'b1);
    chk("R2", {31'd0, s_int}, 32'd1);
    step("R2", 8'h45, 8'h00, 1'b0, 20'hE8000, 1'b1, 1'b0);
    chk("R2", {31'd0, s_ext}, 32'd1);

    // R8: write and access in the same cycle
    step("R8", 8'h47, 8'h01, 1'b1, 20'hC0000, 1'b1, 1'b1);
    chk("R8", {31'd0, s_ext}, 32'd1);
    step("R8", 8'h47, 8'h00, 1'b0, 20'hC0000, 1'b1, 1'b1);
    chk("R8", {31'd0, s_int}, 32'd1);

    // R12: out-of-range writes have no effect
    step("R12", 8'h40, 8'hFF, 1'b1, 20'hC0000, 1'b0, 1'b0);
    step("R12", 8'h48, 8'hFF, 1'b1, 20'hC0000, 1'b0, 1'b0);
    step("R12", 8'h40, 8'h00, 1'b0, 20'hC0000, 1'b1, 1'b0);
    chk("R12", {24'd0, s_rd}, 32'h0);
    chk("R12", {31'd0, s_ext}, 32'd1);
    step("R12", 8'h47, 8'h00, 1'b0, 20'hC4000, 1'b1, 1'b1);
    chk("R12", {24'd0, s_rd}, 32'h01);
    chk("R12", {31'd0, s_ext}, 32'd1);

    // R11: idle cycle
    step("R11", 8'h44, 8'h00, 1'b0, 20'hC0000, 1'b0, 1'b1);

    // R7: random mix of writes and accesses
    for (int n = 0; n < 4000; n++) begin
      logic [7:0]  ca;
      logic [19:0] ma;
      ca = ($urandom % 8 != 0) ? 8'(8'h44 + $urandom % 4) : 8'($urandom);
      ma = ($urandom % 4 != 0) ? 20'(20'hC0000 + $urandom % 32'h40000) : 20'($urandom);
      step("R7", ca, 8'($urandom), ($urandom % 3 == 0), ma,
           ($urandom % 8 != 0), 1'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule